// File: doc/BRIEF.md
# Code Memory Lock Guard

This block turns a small set of one-time-settable protection bits into a protection level. It uses that level to allow or refuse each class of access to on-chip code memory. A microcontroller core presents four kinds of request to it: table-read fetches of internal code bytes by a program running from external memory, programming writes, verify reads, and execution from external memory. The block answers each request one clock later with either a grant or a deny pulse. The levels are cumulative: each higher level refuses everything the level below it refuses, plus one more class.

The protection bits are modelled as registers. Each bit can be set on its own through an indexed set strobe. A plain reset does not clear them, and only a chip-erase strobe clears all of them at once. While the lowest bit is set, a reset cycle captures the level of the external-access pin into a latch. A mismatch flag warns when that latch disagrees with the live pin.

Top module: `code_lock_guard`

## Requirements
- R1: `prot_level` encodes the protection level as follows: 0 means all bits clear and no protection; 1 means bit 0 is set; 2 means bits 0 and 1 are set; 3 means all three bits are set. `prot_level` updates on the clock edge after the bits change. At level 0 every request is granted.
- R2: A bit pattern outside the four legal ones maps to the level of its highest set bit plus one, so protection never weakens. For example, pattern 010 gives level 2, and patterns 100 and 101 give level 3.
- R3: At level 1 or higher, table-read requests (`req` bit 0) and programming requests (`req` bit 1) are denied.
- R4: At level 2 or higher, verify requests (`req` bit 2) are also denied.
- R5: At level 3, external-execution requests (`req` bit 3) are also denied.
- R6: For each request bit sampled high at a clock edge, exactly one of `grant`/`deny` at the same bit position is high after that edge. With no request, both are low. While `rst` is high, both are cleared.
- R7: A one-cycle `lock_set` pulse sets the bit chosen by `lock_set_idx`. An index of 3 or above changes nothing. `rst` never clears a bit.
- R8: `chip_erase` clears every bit at the next edge and takes priority over a `lock_set` in the same cycle.
- R9: At a clock edge where `rst` is high and bit 0 was already set, `ea_latched` takes the value of `ea_pin`. At every other edge it holds its value.
- R10: `ea_mismatch` is high after an edge exactly when bit 0 is set and `ea_latched` differs from `ea_pin`. It is low while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lock_set | input | 1 | Strobe that sets one protection bit |
| lock_set_idx | input | 2 | Index of the bit to set |
| chip_erase | input | 1 | Strobe that clears all protection bits |
| ea_pin | input | 1 | Live level of the external-access pin |
| req | input | 4 | Access requests: bit 0 table read, bit 1 program, bit 2 verify, bit 3 external execution |
| grant | output | 4 | Registered grant per request class |
| deny | output | 4 | Registered deny per request class |
| prot_level | output | 2 | Current protection level, 0 to 3 |
| ea_latched | output | 1 | External-access level captured at reset |
| ea_mismatch | output | 1 | Latched and live external-access levels disagree while bit 0 is set |

## Verification
The in-RTL assertions check the following on every cycle:
- an erase always empties the bit store;
- bits never drop without an erase;
- a set top bit forces the highest level;
- external execution is refused at the top level;
- an unprotected part grants exactly what it was asked;
- the access latch holds outside reset;
- the mismatch flag stays low without bit 0.

Only the bench scenarios can show the following:
- the full level-by-class matrix, including the illegal bit patterns;
- erase winning over a simultaneous set;
- bits surviving a reset;
- the latch refusing to sample when a reset arrives with bit 0 still clear.

// File: rtl/clg_pkg.sv
package clg_pkg;

  // Access classes presented on the request bus
  localparam int N_CLASS   = 4;
  localparam int CL_TBLRD  = 0;
  localparam int CL_PROG   = 1;
  localparam int CL_VERIFY = 2;
  localparam int CL_EXTEX  = 3;

  typedef enum logic [1:0] {
    PL_OPEN     = 2'd0,
    PL_NOWRITE  = 2'd1,
    PL_NOVERIFY = 2'd2,
    PL_NOEXT    = 2'd3
  } prot_level_e;

  // Lowest protection level at which a class is refused
  function automatic int deny_from(input int cls);
    case (cls)
      CL_TBLRD:  deny_from = int'(PL_NOWRITE);
      CL_PROG:   deny_from = int'(PL_NOWRITE);
      CL_VERIFY: deny_from = int'(PL_NOVERIFY);
      default:   deny_from = int'(PL_NOEXT);
    endcase
  endfunction

endpackage

// File: rtl/clg_lock_store.sv
module clg_lock_store #(
  parameter int LB_COUNT = 3,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lock_set,
  input  logic [IDX_W-1:0]    lock_set_idx,
  input  logic                chip_erase,
  output logic [LB_COUNT-1:0] lock_q
);

  // Nonvolatile model: power-up value only, never touched by rst
  logic [LB_COUNT-1:0] bits_q = '0;

  always_ff @(posedge clk) begin
    if (chip_erase) begin
      bits_q <= '0;
    end else begin
      for (int b = 0; b < LB_COUNT; b++) begin
        if (lock_set && (lock_set_idx == IDX_W'(b)))
          bits_q[b] <= 1'b1;
      end
    end
  end

  assign lock_q = bits_q;

  p_erase_clears_r8: assert property (@(posedge clk) disable iff (rst)
    chip_erase |=> (bits_q == '0));

  p_bits_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !chip_erase |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

endmodule

// File: rtl/clg_level_decode.sv
module clg_level_decode #(
  parameter int LB_COUNT = 3,
  parameter int LVL_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LB_COUNT-1:0] lock_q,
  output logic [LVL_W-1:0]    level_q
);

  logic [LVL_W-1:0] lvl_d;
  logic [LVL_W-1:0] lvl_r = '0;

  // Highest set bit wins, so partial patterns never lower protection
  always_comb begin
    lvl_d = '0;
    for (int b = 0; b < LB_COUNT; b++) begin
      if (lock_q[b]) lvl_d = LVL_W'(b + 1);
    end
  end

  // Level tracks the bits regardless of reset: protection must not lapse
  always_ff @(posedge clk) lvl_r <= lvl_d;

  assign level_q = lvl_r;

  p_top_bit_max_r2: assert property (@(posedge clk) disable iff (rst)
    lock_q[LB_COUNT-1] |=> (lvl_r == LVL_W'(LB_COUNT)));

endmodule

// File: rtl/clg_ea_latch.sv
module clg_ea_latch (
  input  logic clk,
  input  logic rst,
  input  logic lb_first,
  input  logic ea_pin,
  output logic ea_q,
  output logic mismatch_q
);

  // Arbitrary until the first qualifying reset; modelled as 0
  logic ea_r  = 1'b0;
  logic mis_r = 1'b0;

  always_ff @(posedge clk) begin
    if (rst && lb_first) ea_r <= ea_pin;
  end

  always_ff @(posedge clk) begin
    if (rst) mis_r <= 1'b0;
    else     mis_r <= lb_first && (ea_r != ea_pin);
  end

  assign ea_q       = ea_r;
  assign mismatch_q = mis_r;

  p_latch_holds_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ea_r));

endmodule

// File: rtl/clg_access_gate.sv
module clg_access_gate
  import clg_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LVL_W-1:0]   level_q,
  input  logic [N_CLASS-1:0] req,
  output logic [N_CLASS-1:0] grant_q,
  output logic [N_CLASS-1:0] deny_q
);

  generate
    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
      logic allow;
      assign allow = (int'(level_q) < deny_from(c));

      always_ff @(posedge clk) begin
        if (rst) begin
          grant_q[c] <= 1'b0;
          deny_q[c]  <= 1'b0;
        end else begin
          grant_q[c] <= req[c] && allow;
          deny_q[c]  <= req[c] && !allow;
        end
      end
    end
  endgenerate

  p_ext_exec_denied_r5: assert property (@(posedge clk) disable iff (rst)
    (req[CL_EXTEX] && (level_q == LVL_W'(PL_NOEXT))) |=> deny_q[CL_EXTEX]);

  p_open_grants_all_r1: assert property (@(posedge clk) disable iff (rst)
    (level_q == '0) |=> ((grant_q == $past(req)) && (deny_q == '0)));

endmodule

// File: rtl/code_lock_guard.sv
module code_lock_guard
  import clg_pkg::*;
#(
  parameter int LB_COUNT = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               lock_set,
  input  logic [$clog2(LB_COUNT+1)-1:0]      lock_set_idx,
  input  logic                               chip_erase,
  input  logic                               ea_pin,
  input  logic [3:0]                         req,
  output logic [3:0]                         grant,
  output logic [3:0]                         deny,
  output logic [$clog2(LB_COUNT+1)-1:0]      prot_level,
  output logic                               ea_latched,
  output logic                               ea_mismatch
);

  localparam int LVL_W = $clog2(LB_COUNT + 1);

  logic [LB_COUNT-1:0] lock_q;
  logic [LVL_W-1:0]    level_q;

  clg_lock_store #(.LB_COUNT(LB_COUNT), .IDX_W(LVL_W)) u_store (
    .clk(clk), .rst(rst), .lock_set(lock_set), .lock_set_idx(lock_set_idx),
    .chip_erase(chip_erase), .lock_q(lock_q)
  );

  clg_level_decode #(.LB_COUNT(LB_COUNT), .LVL_W(LVL_W)) u_decode (
    .clk(clk), .rst(rst), .lock_q(lock_q), .level_q(level_q)
  );

  clg_ea_latch u_ea (
    .clk(clk), .rst(rst), .lb_first(lock_q[0]), .ea_pin(ea_pin),
    .ea_q(ea_latched), .mismatch_q(ea_mismatch)
  );

  clg_access_gate #(.LVL_W(LVL_W)) u_gate (
    .clk(clk), .rst(rst), .level_q(level_q), .req(req),
    .grant_q(grant), .deny_q(deny)
  );

  assign prot_level = level_q;

  p_no_mismatch_unlocked_r10: assert property (@(posedge clk) disable iff (rst)
    !lock_q[0] |=> !ea_mismatch);

endmodule

// File: tb/code_lock_guard_tb.sv
module code_lock_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock_set = 1'b0;
  logic [1:0] lock_set_idx = '0;
  logic       chip_erase = 1'b0;
  logic       ea_pin = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] grant, deny;
  logic [1:0] prot_level;
  logic       ea_latched, ea_mismatch;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4ns clk = ~clk;

  code_lock_guard dut_i (
    .clk(clk), .rst(rst), .lock_set(lock_set), .lock_set_idx(lock_set_idx),
    .chip_erase(chip_erase), .ea_pin(ea_pin), .req(req), .grant(grant),
    .deny(deny), .prot_level(prot_level), .ea_latched(ea_latched),
    .ea_mismatch(ea_mismatch)
  );

  // {lock bits[2:0], req[3:0], level[1:0], grant[3:0], deny[3:0]}
  localparam logic [16:0] VEC [10] = '{
    {3'b000, 4'b1111, 2'd0, 4'b1111, 4'b0000},
    {3'b001, 4'b1111, 2'd1, 4'b1100, 4'b0011},
    {3'b011, 4'b1111, 2'd2, 4'b1000, 4'b0111},
    {3'b111, 4'b1111, 2'd3, 4'b0000, 4'b1111},
    {3'b010, 4'b1111, 2'd2, 4'b1000, 4'b0111},
    {3'b100, 4'b1111, 2'd3, 4'b0000, 4'b1111},
    {3'b101, 4'b0101, 2'd3, 4'b0000, 4'b0101},
    {3'b001, 4'b0100, 2'd1, 4'b0100, 4'b0000},
    {3'b000, 4'b0000, 2'd0, 4'b0000, 4'b0000},
    {3'b011, 4'b1010, 2'd2, 4'b1000, 4'b0010}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic erase_all();
    chip_erase = 1'b1; tick(); chip_erase = 1'b0; tick(); tick();
  endtask

  task automatic set_bits(input logic [2:0] bits);
    for (int b = 0; b < 3; b++) begin
      if (bits[b]) begin
        lock_set = 1'b1; lock_set_idx = 2'(b); tick();
        lock_set = 1'b0; tick();
      end
    end
    tick(); tick();
  endtask

  task automatic pulse_reset(input logic pin);
    ea_pin = pin; rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
  endtask

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // Reset state
    check("R6 reset grant", int'(grant), 0);
    check("R6 reset deny", int'(deny), 0);
    check("R1 reset level", int'(prot_level), 0);
    check("R10 reset mismatch", int'(ea_mismatch), 0);

    // Level/class matrix (R1 R2 R3 R4 R5 R6)
    for (int i = 0; i < 10; i++) begin
      erase_all();
      set_bits(VEC[i][16:14]);
      req = VEC[i][13:10]; tick(); req = '0;
      check($sformatf("R1/R2 level vec%0d", i), int'(prot_level), int'(VEC[i][9:8]));
      check($sformatf("R3/R4/R5 grant vec%0d", i), int'(grant), int'(VEC[i][7:4]));
      check($sformatf("R6 deny vec%0d", i), int'(deny), int'(VEC[i][3:0]));
    end

    // R8: erase beats a simultaneous set
    erase_all();
    lock_set = 1'b1; lock_set_idx = 2'd2; chip_erase = 1'b1; tick();
    lock_set = 1'b0; chip_erase = 1'b0; tick(); tick();
    check("R8 erase priority", int'(prot_level), 0);

    // R7: index 3 is ignored
    lock_set = 1'b1; lock_set_idx = 2'd3; tick(); lock_set = 1'b0; tick(); tick();
    check("R7 index 3 ignored", int'(prot_level), 0);

    // R6: reset clears grants even with requests
    req = 4'b1111; rst = 1'b1; tick();
    check("R6 grant in reset", int'(grant), 0);
    check("R6 deny in reset", int'(deny), 0);
    req = '0; rst = 1'b0; tick();

    // R7/R9/R10: bit 0 survives reset, latch samples pin
    set_bits(3'b001);
    pulse_reset(1'b1);
    tick();
    check("R7 bits survive reset", int'(prot_level), 1);
    check("R9 latch sampled", int'(ea_latched), 1);
    check("R10 no mismatch equal", int'(ea_mismatch), 0);
    ea_pin = 1'b0; tick(); tick();
    check("R10 mismatch raised", int'(ea_mismatch), 1);
    ea_pin = 1'b1; tick(); tick();
    check("R10 mismatch cleared", int'(ea_mismatch), 0);
    ea_pin = 1'b0; tick(); tick();
    check("R10 mismatch again", int'(ea_mismatch), 1);

    // R8/R10: erase unlocks, flag drops
    erase_all();
    check("R8 erase level", int'(prot_level), 0);
    check("R10 unlocked no flag", int'(ea_mismatch), 0);

    // R9: reset with bit 0 clear must not sample
    pulse_reset(1'b0);
    check("R9 latch held", int'(ea_latched), 1);
    ea_pin = 1'b1;
    set_bits(3'b001);
    check("R10 held latch matches", int'(ea_mismatch), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule